// File: doc/BRIEF.md
# SPI Slave Register Access Frontend

This block lets an external SPI master read and write a small bank of 8-bit registers through fixed 16-bit frames. The first master byte carries a direction flag, a 5-bit register address, a parity bit and one unused bit. The second master byte carries write data; it carries nothing during a read. While the master shifts its frame in, the slave shifts out the system status byte first and then the contents of the addressed register.

All SPI pins are oversampled in the system clock domain. A two-flop synchronizer feeds an edge detector. The frame engine counts the sampling edges, latches the addressed register's contents when the parity bit arrives, and decides on the rising edge of slave select whether the frame commits a write. A committed write shows as a one-cycle strobe with address and data. A frame with the wrong edge count, or a write whose parity does not match, raises a one-cycle error pulse and writes nothing. The included register model keeps the status byte at address 0x0C, and that byte comes from an input.

The serial clock idles low. MISO changes after each rising edge and MOSI is sampled on each falling edge, MSB first. The system clock must run at least four times faster than the serial clock.

Top module: `spi_regacc_top`

## Requirements
- R1: `miso_oe` is 0 while `ss_n` is high and after reset. It goes to 1 after `ss_n` falls and returns to 0 after `ss_n` rises. `miso` reads 0 whenever `miso_oe` is 0.
- R2: The first 8 bits shifted out on MISO, MSB first, are the status byte (`sys_status` sampled when `ss_n` falls). This holds for reads and writes and for every address.
- R3: Bits 9 to 16 on MISO are the contents of the addressed register. They are latched when the 7th falling edge (the parity bit) is sampled, so a write frame returns the value held before the write.
- R4: The header byte is {rw, addr[4:0], par, spare}, MSB first, and rw=0 marks a write. When exactly 16 falling edges occur and par equals the XOR of rw and addr, the rising edge of `ss_n` produces one `wr_strobe` pulse carrying `wr_addr`=addr and `wr_data`=second byte, and the register model takes the value.
- R5: A write with exactly 16 edges whose par differs from the XOR of rw and addr produces no strobe and one `frame_err` pulse. The register keeps its value.
- R6: A frame with any falling-edge count other than 16 (for example 15 or 17) produces no strobe and one `frame_err` pulse.
- R7: A read (rw=1) with 16 edges produces neither strobe nor error, whatever its parity bit or second master byte.
- R8: The spare bit (bit 0 of the header) has no effect on a write.
- R9: In the register model, address 0x0C always reads `sys_status` and ignores writes. Addresses at or above REG_COUNT (16) read 0.
- R10: After reset, `wr_strobe` and `frame_err` are 0 and every stored register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ss_n | input | 1 | Slave select, active low, asynchronous |
| sclk | input | 1 | Serial clock from master, asynchronous |
| mosi | input | 1 | Serial data from master |
| sys_status | input | 8 | Live system status byte |
| miso | output | 1 | Serial data to master |
| miso_oe | output | 1 | MISO driver enable; 0 means high impedance |
| wr_strobe | output | 1 | One-cycle pulse on a committed write |
| wr_addr | output | 5 | Address of the committed write |
| wr_data | output | 8 | Data of the committed write |
| frame_err | output | 1 | One-cycle pulse on a rejected frame |

## Verification
A wrong falling-edge count shows up within one frame. Either a 16-edge write is rejected and `frame_err` pulses, or a short or long frame produces a strobe a few system cycles after `ss_n` rises. If the read latch is taken at the wrong edge, or the transmit index drifts, bits 9 to 16 of the next MISO word are corrupted; a corrupted status hold shows in bits 1 to 8. If the parity or direction decode is faulty, a stored value changes when it should not, and the following read frame exposes it. If the enable is stuck, `miso_oe` is wrong at the first sample inside a frame or right after `ss_n` rises.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;

    localparam int FRAME_BITS = 16;
    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 5;
    localparam logic [ADDR_W-1:0] STATUS_ADDR = 5'h0C;

    typedef struct packed {
        logic              rw;     // 1 = read, 0 = write
        logic [ADDR_W-1:0] addr;
        logic              par;
        logic              spare;
    } hdr_t;

    typedef struct packed {
        hdr_t              hdr;
        logic [BYTE_W-1:0] data;
    } frame_t;

    typedef enum logic [1:0] {
        VD_READ,
        VD_WRITE,
        VD_BAD_PARITY,
        VD_BAD_COUNT
    } verdict_t;

    function automatic logic hdr_parity(input logic rw, input logic [ADDR_W-1:0] addr);
        return ^{rw, addr};
    endfunction

    function automatic verdict_t judge(input hdr_t h, input logic count_ok);
        if (!count_ok)                          return VD_BAD_COUNT;
        if (h.rw)                               return VD_READ;
        if (hdr_parity(h.rw, h.addr) != h.par)  return VD_BAD_PARITY;
        return VD_WRITE;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int              STAGES   = 2,
    parameter int              W        = 3,
    parameter logic [W-1:0]    IDLE_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= IDLE_VAL;
            prev <= IDLE_VAL;
        end else begin
            stg[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            prev <= stg[STAGES-1];
        end
    end

    assign sync_out = stg[STAGES-1];
    assign rise     = sync_out & ~prev;
    assign fall     = ~sync_out & prev;

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import spi_regacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_s,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] status_byte,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              miso_q,
    output logic              miso_oe,
    output logic              wr_strobe,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              frame_err
);
    localparam int CNT_W = $clog2(FRAME_BITS) + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] PAR_IDX  = CNT_W'(ADDR_W + 1);
    localparam logic [CNT_W-1:0] BYTE_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    frame_t             rx;
    logic [CNT_W-1:0]   fall_cnt, rise_cnt;
    logic [BYTE_W-1:0]  stat_hold, rd_hold;
    logic               next_bit;
    verdict_t           verdict;

    // address bits sit in the low end of rx while the parity bit is being sampled
    assign rd_addr = rx[ADDR_W-1:0];
    assign verdict = judge(rx.hdr, fall_cnt == FULL_CNT);

    always_comb begin
        if (rise_cnt < BYTE_CNT)      next_bit = stat_hold[~rise_cnt[2:0]];
        else if (rise_cnt < FULL_CNT) next_bit = rd_hold[~rise_cnt[2:0]];
        else                          next_bit = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx        <= '0;
            fall_cnt  <= '0;
            rise_cnt  <= '0;
            stat_hold <= '0;
            rd_hold   <= '0;
            miso_q    <= 1'b0;
            miso_oe   <= 1'b0;
            wr_strobe <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            frame_err <= 1'b0;
        end else begin
            wr_strobe <= 1'b0;
            frame_err <= 1'b0;
            if (cs_fall) begin
                rx        <= '0;
                fall_cnt  <= '0;
                rise_cnt  <= '0;
                stat_hold <= status_byte;
                miso_q    <= 1'b0;
                miso_oe   <= 1'b1;
            end else if (cs_rise) begin
                miso_oe <= 1'b0;
                case (verdict)
                    VD_WRITE: begin
                        wr_strobe <= 1'b1;
                        wr_addr   <= rx.hdr.addr;
                        wr_data   <= rx.data;
                    end
                    VD_BAD_PARITY, VD_BAD_COUNT: frame_err <= 1'b1;
                    default: ;
                endcase
            end else if (!cs_n_s) begin
                if (sclk_rise) begin
                    miso_q <= next_bit;
                    if (rise_cnt != CNT_MAX) rise_cnt <= rise_cnt + 1'b1;
                end
                if (sclk_fall) begin
                    rx <= {rx[FRAME_BITS-2:0], mosi_s};
                    if (fall_cnt != CNT_MAX) fall_cnt <= fall_cnt + 1'b1;
                    if (fall_cnt == PAR_IDX) rd_hold <= rd_data;
                end
            end
        end
    end

    assert_strobe_full_frame_R4: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> (fall_cnt == FULL_CNT && !rx.hdr.rw));
    assert_strobe_err_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(wr_strobe && frame_err));
    assert_bad_count_rejected_R6: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && fall_cnt != FULL_CNT) |=> (frame_err && !wr_strobe));
    assert_read_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && fall_cnt == FULL_CNT && rx.hdr.rw) |=> (!frame_err && !wr_strobe));
    assert_oe_on_R1: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> miso_oe);
    assert_oe_off_R1: assert property (@(posedge clk) disable iff (rst)
        cs_rise |=> !miso_oe);

endmodule

// File: rtl/spi_reg_model.sv
module spi_reg_model
    import spi_regacc_pkg::*;
#(
    parameter int                REG_COUNT = 16,
    parameter logic [BYTE_W-1:0] RST_VAL   = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] status_in,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int IDX_W = $clog2(REG_COUNT);

    logic [BYTE_W-1:0] regs [REG_COUNT];
    logic wr_hit;

    assign wr_hit = wr_en && (32'(wr_addr) < REG_COUNT) && (wr_addr != STATUS_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_COUNT; i++) regs[i] <= RST_VAL;
        end else if (wr_hit) begin
            regs[wr_addr[IDX_W-1:0]] <= wr_data;
        end
    end

    always_comb begin
        if (rd_addr == STATUS_ADDR)          rd_data = status_in;
        else if (32'(rd_addr) < REG_COUNT)   rd_data = regs[rd_addr[IDX_W-1:0]];
        else                                 rd_data = '0;
    end

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> regs[$past(wr_addr[IDX_W-1:0])] == $past(wr_data));

endmodule

// File: rtl/spi_regacc_top.sv
module spi_regacc_top
    import spi_regacc_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter int                REG_COUNT   = 16,
    parameter logic [BYTE_W-1:0] RST_VAL     = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ss_n,
    input  logic              sclk,
    input  logic              mosi,
    input  logic [BYTE_W-1:0] sys_status,
    output logic              miso,
    output logic              miso_oe,
    output logic              wr_strobe,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              frame_err
);
    // pin vector order: {ss_n, sclk, mosi}
    logic [2:0] pins_s, pins_r, pins_f;
    logic [ADDR_W-1:0] rd_addr;
    logic [BYTE_W-1:0] rd_data;
    logic miso_q;

    spi_pin_sync #(.STAGES(SYNC_STAGES), .W(3), .IDLE_VAL(3'b100)) u_sync (
        .clk(clk), .rst(rst), .async_in({ss_n, sclk, mosi}),
        .sync_out(pins_s), .rise(pins_r), .fall(pins_f)
    );

    spi_frame_engine u_engine (
        .clk(clk), .rst(rst),
        .cs_n_s(pins_s[2]), .cs_fall(pins_f[2]), .cs_rise(pins_r[2]),
        .sclk_rise(pins_r[1]), .sclk_fall(pins_f[1]), .mosi_s(pins_s[0]),
        .status_byte(sys_status), .rd_data(rd_data), .rd_addr(rd_addr),
        .miso_q(miso_q), .miso_oe(miso_oe),
        .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_err(frame_err)
    );

    spi_reg_model #(.REG_COUNT(REG_COUNT), .RST_VAL(RST_VAL)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_strobe), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .status_in(sys_status),
        .rd_data(rd_data)
    );

    assign miso = miso_q & miso_oe;

endmodule

// File: tb/test_spi_regacc_top.sv
`timescale 1ns/1ps
module test_spi_regacc_top;
    localparam int HALF = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic ss_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic [7:0] sys_status = 8'h5A;
    logic miso, miso_oe, wr_strobe, frame_err;
    logic [4:0] wr_addr;
    logic [7:0] wr_data;

    int n_chk = 0, n_bad = 0, n_wr = 0, n_err = 0;
    logic [4:0] last_a;
    logic [7:0] last_d;

    always #2 clk = ~clk;

    spi_regacc_top i_spi_regacc_top (
        .clk(clk), .rst(rst), .ss_n(ss_n), .sclk(sclk), .mosi(mosi),
        .sys_status(sys_status), .miso(miso), .miso_oe(miso_oe),
        .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_err(frame_err)
    );

    always @(negedge clk) if (!rst) begin
        if (wr_strobe) begin n_wr++; last_a = wr_addr; last_d = wr_data; end
        if (frame_err) n_err++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] hdr(input bit rw, input bit [4:0] a, input bit good, input bit x);
        return {rw, a, (^{rw, a}) ^ ~good, x};
    endfunction

    task automatic xfer(input logic [15:0] word, input int nedges,
                        output logic [15:0] got, output int oe_low);
        got = '0; oe_low = 0;
        @(negedge clk) ss_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < nedges; i++) begin
            mosi = (i < 16) ? word[15-i] : 1'b0;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            if (i < 16) got[15-i] = miso;
            if (!miso_oe) oe_low++;
            sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        ss_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] g; int ol;
        chk("R1 oe after reset", miso_oe, 0);
        chk("R1 miso after reset", miso, 0);
        chk("R10 strobe after reset", wr_strobe, 0);
        chk("R10 err after reset", frame_err, 0);
        xfer({hdr(1, 5'd3, 1, 0), 8'h00}, 16, g, ol);
        chk("R10 reg3 reset value", g[7:0], 8'h00);
        chk("R2 status byte on read", g[15:8], 8'h5A);
    endtask

    task automatic t_write_read;
        logic [15:0] g; int ol, w0, e0;
        w0 = n_wr; e0 = n_err;
        xfer({hdr(0, 5'd3, 1, 0), 8'hA5}, 16, g, ol);
        chk("R4 one strobe", n_wr - w0, 1);
        chk("R4 strobe addr", last_a, 5'd3);
        chk("R4 strobe data", last_d, 8'hA5);
        chk("R4 no err", n_err - e0, 0);
        chk("R2 status byte on write", g[15:8], 8'h5A);
        chk("R3 write returns old value", g[7:0], 8'h00);
        chk("R1 oe high in frame", ol, 0);
        chk("R1 oe low after frame", miso_oe, 0);
        w0 = n_wr;
        xfer({hdr(1, 5'd3, 1, 0), 8'h00}, 16, g, ol);
        chk("R3 read back", g[7:0], 8'hA5);
        chk("R7 read no strobe", n_wr - w0, 0);
    endtask

    task automatic t_bad_parity;
        logic [15:0] g; int ol, w0, e0;
        w0 = n_wr; e0 = n_err;
        xfer({hdr(0, 5'd3, 0, 0), 8'h11}, 16, g, ol);
        chk("R5 no strobe", n_wr - w0, 0);
        chk("R5 one err", n_err - e0, 1);
        xfer({hdr(1, 5'd3, 1, 0), 8'h00}, 16, g, ol);
        chk("R5 reg unchanged", g[7:0], 8'hA5);
    endtask

    task automatic t_read_bad_parity;
        logic [15:0] g; int ol, w0, e0;
        w0 = n_wr; e0 = n_err;
        xfer({hdr(1, 5'd3, 0, 0), 8'hFF}, 16, g, ol);
        chk("R7 data despite parity", g[7:0], 8'hA5);
        chk("R7 no err", n_err - e0, 0);
        chk("R7 no strobe", n_wr - w0, 0);
        xfer({hdr(1, 5'd3, 1, 0), 8'h00}, 16, g, ol);
        chk("R7 second byte ignored", g[7:0], 8'hA5);
    endtask

    task automatic t_edge_count;
        logic [15:0] g; int ol, w0, e0;
        w0 = n_wr; e0 = n_err;
        xfer({hdr(0, 5'd3, 1, 0), 8'h77}, 15, g, ol);
        chk("R6 15 edges no strobe", n_wr - w0, 0);
        chk("R6 15 edges err", n_err - e0, 1);
        xfer({hdr(0, 5'd3, 1, 0), 8'h77}, 17, g, ol);
        chk("R6 17 edges no strobe", n_wr - w0, 0);
        chk("R6 17 edges err", n_err - e0, 2);
        xfer({hdr(1, 5'd3, 1, 0), 8'h00}, 16, g, ol);
        chk("R6 reg unchanged", g[7:0], 8'hA5);
    endtask

    task automatic t_spare_bit;
        logic [15:0] g; int ol, w0;
        w0 = n_wr;
        xfer({hdr(0, 5'd5, 1, 1), 8'h3C}, 16, g, ol);
        chk("R8 spare=1 write strobes", n_wr - w0, 1);
        xfer({hdr(1, 5'd5, 1, 1), 8'h00}, 16, g, ol);
        chk("R8 spare=1 data stored", g[7:0], 8'h3C);
    endtask

    task automatic t_status_reg;
        logic [15:0] g; int ol;
        sys_status = 8'hC3;
        repeat (4) @(negedge clk);
        xfer({hdr(1, 5'h0C, 1, 0), 8'h00}, 16, g, ol);
        chk("R9 status both bytes", g, 16'hC3C3);
        xfer({hdr(0, 5'h0C, 1, 0), 8'h00}, 16, g, ol);
        xfer({hdr(1, 5'h0C, 1, 0), 8'h00}, 16, g, ol);
        chk("R9 status not writable", g[7:0], 8'hC3);
        xfer({hdr(0, 5'h1F, 1, 0), 8'h99}, 16, g, ol);
        xfer({hdr(1, 5'h1F, 1, 0), 8'h00}, 16, g, ol);
        chk("R9 out of range reads zero", g[7:0], 8'h00);
        chk("R2 new status on read", g[15:8], 8'hC3);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_read();
        t_bad_parity();
        t_read_bad_parity();
        t_edge_count();
        t_spare_bit();
        t_status_reg();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R1..: actual timeout expected completion");
        finish_run();
    end

endmodule